// File: doc/BRIEF.md
# Exception Entry and Exit Sequencer

This block performs the hardware side of taking and leaving an interrupt handler. When a separate priority controller raises a take request, the sequencer snapshots the core's context and moves the stack pointer down by one frame. It then writes the eight-word frame to memory, one word per accepted beat. After that it reads the handler's vector from a vector table and pulses a handler-start strobe together with the request identifier and the fetched vector. When the handler returns, the sequencer reads the frame back and presents the restored words. It can also skip that work by chaining straight into the next pending handler.

Three shortcuts keep latency low. A more urgent request that arrives while the frame is being written redirects the vector fetch, and the stacking is not restarted. A request pending at handler return goes straight to the next vector fetch. A request that arrives during unstacking abandons the restore and leaves the frame on the stack. A request taken while a handler runs nests a new frame below the current one, up to a parameterised depth. Memory traffic uses a valid/ready handshake with a combinational read response.

Top module: `exc_seq`

## Requirements
- R1: After reset the sequencer is idle: `sp` equals `SP_INIT`, `nest_depth` is 0, and `mem_valid`, `hnd_start` and `restore_valid` are low.
- R2: On a take, `sp` falls by 32 bytes before any frame write. Eight writes follow at `sp+0` through `sp+28`, in word steps of 4. Each write carries the context slot with the same index: slot 0..3 argument registers, 4 = r12, 5 = link, 6 = program counter, 7 = status. The context is captured on the take edge.
- R3: With `mem_ready` held high, `hnd_start` rises exactly 10 cycles after the cycle in which the take request is sampled. This holds both from idle and when preempting a running handler.
- R4: While `mem_ready` is low the sequencer holds its write address and data stable. Stalls only lengthen entry and never change the frame contents.
- R5: The vector is read from `VEC_BASE + 4*id`. `hnd_start` is a one-cycle pulse carrying that id in `hnd_id` and the word read in `hnd_vector`.
- R6: During stacking, a request with a numerically lower `take_prio` (more urgent) replaces the target. Stacking still completes with exactly eight writes. A request of equal priority does not replace the target.
- R7: Once the vector read is being issued, a change of request no longer alters the handler being entered.
- R8: A handler return with `take_req` high performs no stack traffic. `hnd_start` for the new id follows 2 cycles after the return is sampled, and `sp` and `nest_depth` stay unchanged.
- R9: A handler return with no request reads `sp+0` through `sp+28`. `restore_valid` pulses 9 cycles after the return is sampled, with `restore_words` equal to the saved frame. At the same time `sp` rises by 32 and `nest_depth` falls by 1.
- R10: A request during unstacking abandons it. No `restore_valid` is given, `sp` and `nest_depth` stay as they were, and the new handler starts 2 cycles after the request is sampled.
- R11: A take request while a handler runs nests a new frame 32 bytes lower and raises `nest_depth`. At `nest_depth == MAX_NEST` such a request is ignored, with no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_req | input | 1 | Eligible request pending from the priority controller |
| take_id | input | IDW | Identifier of the pending request |
| take_prio | input | PW | Priority of the pending request, lower is more urgent |
| ctx_words | input | 8*DW | Current context, slot k at bits k*DW upward |
| hnd_ret | input | 1 | Running handler returns (one-cycle pulse) |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, valid in the accepting cycle |
| hnd_start | output | 1 | Handler start pulse |
| hnd_id | output | IDW | Identifier of the started handler |
| hnd_vector | output | DW | Fetched vector |
| restore_valid | output | 1 | Restored frame available (pulse) |
| restore_words | output | 8*DW | Restored frame, same slot layout as ctx_words |
| sp | output | AW | Current stack pointer |
| nest_depth | output | $clog2(MAX_NEST+1) | Number of frames on the stack |

## Verification
Entry is exercised with an always-ready memory and with a memory that refuses every third beat. These runs separate the fixed entry latency from a stall-tolerant frame layout, and the frame words in memory expose any mis-ordering of slots or addresses. Request changes during stacking are tried with a more urgent request and with an equal one, and a change during a stalled vector read checks that redirection stops at the fetch. Returns are tried with no request pending, with a request pending at the return, and with a request landing mid-unstack. The pointer, depth and restored words tell normal exit, tail-chaining and abandonment apart. A nested take and a refused take at full depth confirm the frame placement and the depth limit.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int FRAME_WORDS = 8;
  localparam int BEAT_W      = $clog2(FRAME_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STACK,
    ST_VFETCH,
    ST_RUN,
    ST_UNSTACK
  } seq_state_t;
endpackage

// File: rtl/exc_sp_track.sv
module exc_sp_track #(
  parameter int             AW          = 32,
  parameter int             FRAME_BYTES = 32,
  parameter logic [AW-1:0]  SP_INIT     = 32'h100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] STEP = AW'(FRAME_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= SP_INIT;
    end else if (dec) begin
      sp <= sp - STEP;
    end else if (inc) begin
      sp <= sp + STEP;
    end
  end
endmodule

// File: rtl/exc_frame_buf.sv
module exc_frame_buf
  import exc_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      snap_en,
  input  logic [FRAME_WORDS*DW-1:0] ctx_words,
  input  logic [BEAT_W-1:0]         rd_idx,
  output logic [DW-1:0]             rd_word,
  input  logic                      cap_en,
  input  logic [BEAT_W-1:0]         cap_idx,
  input  logic [DW-1:0]             cap_data,
  output logic [FRAME_WORDS*DW-1:0] rest_words
);
  logic [FRAME_WORDS*DW-1:0] snap_flat;

  for (genvar k = 0; k < FRAME_WORDS; k++) begin : g_slot
    logic [DW-1:0] snap_q;
    logic [DW-1:0] rest_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        snap_q <= '0;
        rest_q <= '0;
      end else begin
        if (snap_en) begin
          snap_q <= ctx_words[k*DW +: DW];
        end
        if (cap_en && (cap_idx == BEAT_W'(k))) begin
          rest_q <= cap_data;
        end
      end
    end

    assign snap_flat[k*DW +: DW]  = snap_q;
    assign rest_words[k*DW +: DW] = rest_q;
  end

  assign rd_word = snap_flat[rd_idx*DW +: DW];
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
#(
  parameter int DW       = 32,
  parameter int IDW      = 5,
  parameter int PW       = 3,
  parameter int MAX_NEST = 4,
  localparam int DEP_W   = $clog2(MAX_NEST + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_req,
  input  logic [IDW-1:0]    take_id,
  input  logic [PW-1:0]     take_prio,
  input  logic              hnd_ret,
  input  logic              mem_ready,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic              is_vfetch,
  output logic [BEAT_W-1:0] beat,
  output logic [IDW-1:0]    cur_id,
  output logic              sp_dec,
  output logic              sp_inc,
  output logic              snap_en,
  output logic              cap_en,
  output logic              hnd_start,
  output logic [IDW-1:0]    hnd_id,
  output logic [DW-1:0]     hnd_vector,
  output logic              restore_valid,
  output logic [DEP_W-1:0]  nest_depth
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(FRAME_WORDS - 1);
  localparam logic [DEP_W-1:0]  DEP_MAX   = DEP_W'(MAX_NEST);
  localparam logic [DEP_W-1:0]  DEP_ONE   = DEP_W'(1);

  seq_state_t        state_q;
  logic [BEAT_W-1:0] beat_q;
  logic [IDW-1:0]    cur_id_q;
  logic [PW-1:0]     cur_prio_q;
  logic [DEP_W-1:0]  depth_q;
  logic              beat_done;
  logic              last_beat;
  logic              room;
  logic              start_q;
  logic [IDW-1:0]    start_id_q;
  logic [DW-1:0]     start_vec_q;
  logic              rest_q;

  always_comb begin
    mem_valid = (state_q == ST_STACK) || (state_q == ST_VFETCH) ||
                (state_q == ST_UNSTACK);
    mem_write = (state_q == ST_STACK);
    is_vfetch = (state_q == ST_VFETCH);
    beat_done = mem_valid && mem_ready;
    last_beat = (beat_q == LAST_BEAT);
    room      = (depth_q < DEP_MAX);
    sp_dec    = ((state_q == ST_IDLE) && take_req) ||
                ((state_q == ST_RUN) && !hnd_ret && take_req && room);
    snap_en   = sp_dec;
    cap_en    = (state_q == ST_UNSTACK) && !take_req && beat_done;
    sp_inc    = cap_en && last_beat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      beat_q      <= '0;
      cur_id_q    <= '0;
      cur_prio_q  <= '0;
      depth_q     <= '0;
      start_q     <= 1'b0;
      start_id_q  <= '0;
      start_vec_q <= '0;
      rest_q      <= 1'b0;
    end else begin
      start_q <= 1'b0;
      rest_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_req) begin
            state_q    <= ST_STACK;
            beat_q     <= '0;
            cur_id_q   <= take_id;
            cur_prio_q <= take_prio;
            depth_q    <= depth_q + DEP_ONE;
          end
        end
        ST_STACK: begin
          if (take_req && (take_prio < cur_prio_q)) begin
            cur_id_q   <= take_id;
            cur_prio_q <= take_prio;
          end
          if (beat_done) begin
            if (last_beat) begin
              state_q <= ST_VFETCH;
              beat_q  <= '0;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        ST_VFETCH: begin
          if (beat_done) begin
            state_q     <= ST_RUN;
            start_q     <= 1'b1;
            start_id_q  <= cur_id_q;
            start_vec_q <= mem_rdata;
          end
        end
        ST_RUN: begin
          if (hnd_ret) begin
            beat_q <= '0;
            if (take_req) begin
              state_q    <= ST_VFETCH;
              cur_id_q   <= take_id;
              cur_prio_q <= take_prio;
            end else begin
              state_q <= ST_UNSTACK;
            end
          end else if (take_req && room) begin
            state_q    <= ST_STACK;
            beat_q     <= '0;
            cur_id_q   <= take_id;
            cur_prio_q <= take_prio;
            depth_q    <= depth_q + DEP_ONE;
          end
        end
        ST_UNSTACK: begin
          if (take_req) begin
            state_q    <= ST_VFETCH;
            beat_q     <= '0;
            cur_id_q   <= take_id;
            cur_prio_q <= take_prio;
          end else if (beat_done) begin
            if (last_beat) begin
              rest_q  <= 1'b1;
              depth_q <= depth_q - DEP_ONE;
              beat_q  <= '0;
              state_q <= (depth_q == DEP_ONE) ? ST_IDLE : ST_RUN;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign beat          = beat_q;
  assign cur_id        = cur_id_q;
  assign hnd_start     = start_q;
  assign hnd_id        = start_id_q;
  assign hnd_vector    = start_vec_q;
  assign restore_valid = rest_q;
  assign nest_depth    = depth_q;
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int            DW       = 32,
  parameter int            AW       = 32,
  parameter int            IDW      = 5,
  parameter int            PW       = 3,
  parameter int            MAX_NEST = 4,
  parameter logic [AW-1:0] SP_INIT  = 32'h100,
  parameter logic [AW-1:0] VEC_BASE = 32'h0,
  localparam int           DEP_W    = $clog2(MAX_NEST + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      take_req,
  input  logic [IDW-1:0]            take_id,
  input  logic [PW-1:0]             take_prio,
  input  logic [FRAME_WORDS*DW-1:0] ctx_words,
  input  logic                      hnd_ret,
  output logic                      mem_valid,
  output logic                      mem_write,
  output logic [AW-1:0]             mem_addr,
  output logic [DW-1:0]             mem_wdata,
  input  logic                      mem_ready,
  input  logic [DW-1:0]             mem_rdata,
  output logic                      hnd_start,
  output logic [IDW-1:0]            hnd_id,
  output logic [DW-1:0]             hnd_vector,
  output logic                      restore_valid,
  output logic [FRAME_WORDS*DW-1:0] restore_words,
  output logic [AW-1:0]             sp,
  output logic [DEP_W-1:0]          nest_depth
);
  localparam int WORD_BYTES  = DW / 8;
  localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;

  logic              is_vfetch;
  logic [BEAT_W-1:0] beat;
  logic [IDW-1:0]    cur_id;
  logic              sp_dec;
  logic              sp_inc;
  logic              snap_en;
  logic              cap_en;

  exc_seq_ctrl #(
    .DW(DW), .IDW(IDW), .PW(PW), .MAX_NEST(MAX_NEST)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .take_req(take_req), .take_id(take_id), .take_prio(take_prio),
    .hnd_ret(hnd_ret),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write),
    .is_vfetch(is_vfetch), .beat(beat), .cur_id(cur_id),
    .sp_dec(sp_dec), .sp_inc(sp_inc), .snap_en(snap_en), .cap_en(cap_en),
    .hnd_start(hnd_start), .hnd_id(hnd_id), .hnd_vector(hnd_vector),
    .restore_valid(restore_valid), .nest_depth(nest_depth)
  );

  exc_sp_track #(
    .AW(AW), .FRAME_BYTES(FRAME_BYTES), .SP_INIT(SP_INIT)
  ) u_sp (
    .clk(clk), .rst(rst), .dec(sp_dec), .inc(sp_inc), .sp(sp)
  );

  exc_frame_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst(rst),
    .snap_en(snap_en), .ctx_words(ctx_words),
    .rd_idx(beat), .rd_word(mem_wdata),
    .cap_en(cap_en), .cap_idx(beat), .cap_data(mem_rdata),
    .rest_words(restore_words)
  );

  always_comb begin
    if (is_vfetch) begin
      mem_addr = VEC_BASE + AW'(cur_id) * AW'(WORD_BYTES);
    end else begin
      mem_addr = sp + AW'(beat) * AW'(WORD_BYTES);
    end
  end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int DW       = 32,
  parameter int AW       = 32,
  parameter int MAX_NEST = 4,
  localparam int DEP_W   = $clog2(MAX_NEST + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_valid,
  input logic             mem_write,
  input logic             mem_ready,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_wdata,
  input logic             hnd_start,
  input logic             restore_valid,
  input logic [AW-1:0]    sp,
  input logic [DEP_W-1:0] nest_depth
);
  localparam logic [AW-1:0] FB = AW'(8 * (DW / 8));

  assert_write_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_write && !mem_ready) |=>
      (mem_valid && mem_write && $stable(mem_addr) && $stable(mem_wdata)));

  assert_frame_window_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_write) |-> ((mem_addr >= sp) && (mem_addr < sp + FB)));

  assert_start_after_read_R5: assert property (@(posedge clk) disable iff (rst)
    hnd_start |-> $past(mem_valid && !mem_write && mem_ready));

  assert_sp_step_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp) |-> ((sp == $past(sp) - FB) || (sp == $past(sp) + FB)));

  assert_restore_sp_R9: assert property (@(posedge clk) disable iff (rst)
    restore_valid |-> (sp == $past(sp) + FB));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hnd_start, restore_valid}));

  assert_depth_limit_R11: assert property (@(posedge clk) disable iff (rst)
    nest_depth <= DEP_W'(MAX_NEST));
endmodule

bind exc_seq exc_seq_chk #(.DW(DW), .AW(AW), .MAX_NEST(MAX_NEST)) u_chk (
  .clk(clk), .rst(rst),
  .mem_valid(mem_valid), .mem_write(mem_write), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .hnd_start(hnd_start), .restore_valid(restore_valid),
  .sp(sp), .nest_depth(nest_depth)
);

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int IDW = 5;
  localparam int PW = 3;
  localparam int MAXN = 2;
  localparam int DEP_W = $clog2(MAXN + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic take_req = 1'b0;
  logic [IDW-1:0] take_id = '0;
  logic [PW-1:0] take_prio = '0;
  logic [8*DW-1:0] ctx_words = '0;
  logic hnd_ret = 1'b0;
  logic mem_valid, mem_write;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_ready = 1'b1;
  logic [DW-1:0] mem_rdata;
  logic hnd_start;
  logic [IDW-1:0] hnd_id;
  logic [DW-1:0] hnd_vector;
  logic restore_valid;
  logic [8*DW-1:0] restore_words;
  logic [AW-1:0] sp;
  logic [DEP_W-1:0] nest_depth;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int nwr = 0;
  int nrd = 0;
  bit rv_seen = 0;
  bit stall = 0;
  bit hold = 0;
  bit done = 0;
  logic [DW-1:0] mem [128];

  always #2.5 clk = ~clk;

  exc_seq #(.DW(DW), .AW(AW), .IDW(IDW), .PW(PW), .MAX_NEST(MAXN),
            .SP_INIT(32'h100), .VEC_BASE(32'h0)) u_exc_seq (
    .clk(clk), .rst(rst), .take_req(take_req), .take_id(take_id),
    .take_prio(take_prio), .ctx_words(ctx_words), .hnd_ret(hnd_ret),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .hnd_start(hnd_start), .hnd_id(hnd_id), .hnd_vector(hnd_vector),
    .restore_valid(restore_valid), .restore_words(restore_words),
    .sp(sp), .nest_depth(nest_depth));

  assign mem_rdata = mem[mem_addr[8:2]];

  always @(posedge clk) begin
    if (mem_valid && mem_write && mem_ready) mem[mem_addr[8:2]] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sample at the falling edge, then drive the next cycle's inputs
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (mem_valid && mem_ready && mem_write) nwr++;
    if (mem_valid && mem_ready && !mem_write) nrd++;
    if (restore_valid) rv_seen = 1;
    hnd_ret = 1'b0;
    mem_ready = hold ? 1'b0 : (stall ? ((cyc % 3) != 0) : 1'b1);
  endtask

  task automatic clr();
    nwr = 0; nrd = 0; rv_seen = 0;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      tick(); n++;
      if (hnd_start) break;
    end
  endtask

  task automatic wait_restore(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      tick(); n++;
      if (restore_valid) break;
    end
  endtask

  function automatic logic [8*DW-1:0] mk_ctx(input logic [15:0] tag);
    logic [8*DW-1:0] v;
    for (int k = 0; k < 8; k++) v[k*DW +: DW] = {tag, 16'(k)};
    return v;
  endfunction

  task automatic req(input int id, input int pr);
    take_req = 1'b1; take_id = IDW'(id); take_prio = PW'(pr);
  endtask

  task automatic frame_check(input string r, input int base_word, input logic [8*DW-1:0] c);
    for (int k = 0; k < 8; k++)
      check(mem[base_word + k] == c[k*DW +: DW], r, mem[base_word + k], c[k*DW +: DW]);
  endtask

  task automatic t_reset();
    check(sp == 32'h100, "R1 sp", sp, 32'h100);
    check(nest_depth == 0, "R1 depth", nest_depth, 0);
    check(!mem_valid && !hnd_start && !restore_valid, "R1 idle outputs",
          {mem_valid, hnd_start, restore_valid}, 0);
  endtask

  task automatic t_entry_exit();
    int n;
    logic [8*DW-1:0] c = mk_ctx(16'h1111);
    ctx_words = c; clr();
    req(5, 4);
    wait_start(n);
    take_req = 1'b0;
    check(n == 10, "R3 entry latency from idle", n, 10);
    check(hnd_id == 5, "R5 handler id", hnd_id, 5);
    check(hnd_vector == 32'hA000_0005, "R5 vector", hnd_vector, 32'hA000_0005);
    check(sp == 32'hE0, "R2 sp after entry", sp, 32'hE0);
    check(nwr == 8 && nrd == 1, "R2 write/read count", {nwr, nrd}, {32'd8, 32'd1});
    ctx_words = mk_ctx(16'hDEAD);
    frame_check("R2 frame slot order", 56, c);
    tick();
    check(!hnd_start, "R5 start is one pulse", hnd_start, 0);
    clr(); hnd_ret = 1'b1;
    wait_restore(n);
    check(n == 9, "R9 return latency", n, 9);
    check(restore_words == c, "R9 restored words", restore_words, c);
    check(sp == 32'h100 && nest_depth == 0, "R9 sp and depth", {sp, 32'(nest_depth)},
          {32'h100, 32'd0});
    check(nrd == 8 && nwr == 0, "R9 read count", {nrd, nwr}, {32'd8, 32'd0});
    tick();
  endtask

  task automatic t_stall();
    int n;
    logic [8*DW-1:0] c = mk_ctx(16'h2222);
    ctx_words = c; stall = 1; clr();
    req(3, 2);
    wait_start(n);
    take_req = 1'b0;
    ctx_words = mk_ctx(16'hBEEF);
    check(n > 10, "R4 stalls lengthen entry", n, 11);
    check(hnd_id == 3 && hnd_vector == 32'hA000_0003, "R4 id under stall",
          hnd_vector, 32'hA000_0003);
    frame_check("R4 frame under stall", 56, c);
    check(nwr == 8, "R4 exactly eight writes", nwr, 8);
    hnd_ret = 1'b1;
    wait_restore(n);
    check(restore_words == c && sp == 32'h100, "R4 restore under stall",
          restore_words, c);
    stall = 0;
    tick();
  endtask

  task automatic t_late();
    int n;
    logic [8*DW-1:0] c = mk_ctx(16'h3333);
    ctx_words = c; clr();
    req(9, 5);
    tick(); tick(); tick();
    req(2, 1);
    wait_start(n);
    take_req = 1'b0;
    check(n == 7, "R6 late arrival keeps fixed entry", n, 7);
    check(hnd_id == 2 && hnd_vector == 32'hA000_0002, "R6 redirected to urgent",
          hnd_id, 2);
    check(nwr == 8, "R6 no restart of stacking", nwr, 8);
    frame_check("R6 frame intact", 56, c);
    clr();
    hnd_ret = 1'b1; req(9, 5);
    wait_start(n);
    take_req = 1'b0;
    check(n == 2, "R8 tail chain latency", n, 2);
    check(hnd_id == 9, "R8 tail chain id", hnd_id, 9);
    check(nwr == 0 && nrd == 1 && sp == 32'hE0 && nest_depth == 1,
          "R8 no stack traffic", {nwr, nrd, sp}, {32'd0, 32'd1, 32'hE0});
    hnd_ret = 1'b1;
    wait_restore(n);
    check(restore_words == c, "R8 frame still valid after chain", restore_words, c);
    tick();
    // equal priority must not redirect
    req(9, 5);
    tick(); tick();
    req(4, 5);
    wait_start(n);
    take_req = 1'b0;
    check(hnd_id == 9, "R6 equal priority not redirected", hnd_id, 9);
    hnd_ret = 1'b1;
    wait_restore(n);
    tick();
  endtask

  task automatic t_window_nest();
    int n;
    logic [8*DW-1:0] c1 = mk_ctx(16'h4444);
    logic [8*DW-1:0] c2 = mk_ctx(16'h5555);
    ctx_words = c1; clr();
    req(9, 5);
    for (int i = 0; i < 9; i++) tick();
    hold = 1; mem_ready = 1'b0;
    req(2, 1);
    tick(); tick();
    check(mem_valid && !mem_write && mem_addr == 32'h24, "R7 vector read pending",
          mem_addr, 32'h24);
    hold = 0; mem_ready = 1'b1;
    ctx_words = c2;
    wait_start(n);
    check(hnd_id == 9, "R7 window closed at fetch", hnd_id, 9);
    // request 2 still pending and more urgent: nests
    clr();
    wait_start(n);
    take_req = 1'b0;
    check(n == 10, "R3 entry latency from handler", n, 10);
    check(hnd_id == 2 && sp == 32'hC0 && nest_depth == 2, "R11 nested frame",
          {32'(hnd_id), sp}, {32'd2, 32'hC0});
    frame_check("R11 nested frame words", 48, c2);
    frame_check("R11 outer frame kept", 56, c1);
    // at max depth a new request is ignored
    clr(); req(0, 0);
    for (int i = 0; i < 12; i++) tick();
    check(nwr == 0 && nrd == 0 && nest_depth == 2 && sp == 32'hC0,
          "R11 ignored at max depth", {nwr, nrd}, 0);
    take_req = 1'b0;
    hnd_ret = 1'b1;
    wait_restore(n);
    check(restore_words == c2 && nest_depth == 1 && sp == 32'hE0,
          "R9 inner restore", restore_words, c2);
    hnd_ret = 1'b1;
    wait_restore(n);
    check(restore_words == c1 && nest_depth == 0 && sp == 32'h100,
          "R9 outer restore", restore_words, c1);
    tick();
  endtask

  task automatic t_pop();
    int n;
    logic [8*DW-1:0] c = mk_ctx(16'h6666);
    ctx_words = c; clr();
    req(6, 3);
    wait_start(n);
    take_req = 1'b0;
    clr(); hnd_ret = 1'b1;
    tick(); tick(); tick();
    req(8, 3);
    wait_start(n);
    take_req = 1'b0;
    check(n == 2, "R10 new handler after abandon", n, 2);
    check(hnd_id == 8, "R10 new handler id", hnd_id, 8);
    check(!rv_seen, "R10 no restore on abandon", rv_seen, 0);
    check(sp == 32'hE0 && nest_depth == 1, "R10 frame left on stack",
          {sp, 32'(nest_depth)}, {32'hE0, 32'd1});
    frame_check("R10 frame unchanged", 56, c);
    hnd_ret = 1'b1;
    wait_restore(n);
    check(restore_words == c && sp == 32'h100, "R10 later restore", restore_words, c);
    tick();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = (i < 32) ? (32'hA000_0000 + 32'(i)) : 32'h0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_entry_exit();
    t_stall();
    t_late();
    t_window_nest();
    t_pop();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule